// File: doc/BRIEF.md
# Two's Complement Add/Subtract Unit with Condition Flags

This block is a combinational N-bit integer arithmetic unit. It supports four operations: plain addition, addition that takes a carry from an earlier step, subtraction, and negation. All four run through one ripple carry chain. Subtraction and negation feed the chain with the bitwise inverse of an operand and force the lowest carry input to 1. The unit returns the N-bit result together with four condition flags (negative, zero, carry and signed overflow). The flags are valid in the same cycle as the result.

Signed overflow is found by comparing the carry entering the top bit of the chain with the carry leaving it. The carry that leaves the top bit is not part of the result; it appears only on the carry flag. Negation is computed as zero minus the operand. Negating the most negative value therefore returns the same pattern and raises overflow.

A small register holds the four flags. It loads when an enable is high, so a later add-with-carry can take its carry from it. The carry is wired back by the user, outside the block.

Top module: `arith_flag_unit`

## Requirements
- R1: With `op_sel` = 00 (add), `{carry, result}` equals `op_a + op_b` taken as unsigned (W+1)-bit values, and `carry_in` has no effect.
- R2: With `op_sel` = 01 (add-with-carry), `{carry, result}` equals `op_a + op_b + carry_in` taken as unsigned values.
- R3: With `op_sel` = 10 (subtract), `result` equals `op_a - op_b` modulo 2^W, and `carry` is 1 exactly when `op_a >= op_b` taken as unsigned values (1 means no borrow).
- R4: With `op_sel` = 11 (negate), `result` equals `0 - op_a` modulo 2^W, `op_b` and `carry_in` have no effect, and `carry` is 1 only when `op_a` is zero.
- R5: `ovf` is 1 exactly when the signed (two's complement) value of the exact operation falls outside [-2^(W-1), 2^(W-1)-1]. This is the case in which the carry into the top bit differs from the carry out of it.
- R6: An add or add-with-carry of two operands whose top bits differ never sets `ovf`, whatever the carry.
- R7: A subtract sets `ovf` exactly when the operands' top bits differ and the result's top bit differs from that of `op_a`.
- R8: Negating the most negative value (top bit 1, all other bits 0) returns that same pattern with `ovf` = 1.
- R9: `neg` equals the top bit of `result`, and `zero` is 1 exactly when every bit of `result` is 0.
- R10: While `rst_n` is low, `flags_q` is 0. At a rising clock edge with `flag_we` = 1, `flags_q` loads `{neg, zero, carry, ovf}` (bit 3 down to bit 0). With `flag_we` = 0 it keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| op_a | input | W | First operand (the operand negated by the negate operation) |
| op_b | input | W | Second operand |
| op_sel | input | 2 | Operation: 00 add, 01 add-with-carry, 10 subtract, 11 negate |
| carry_in | input | 1 | Incoming carry flag, used only by add-with-carry |
| flag_we | input | 1 | Load enable of the flag register |
| result | output | W | Arithmetic result |
| neg | output | 1 | Negative flag |
| zero | output | 1 | Zero flag |
| carry | output | 1 | Carry out of the top bit |
| ovf | output | 1 | Signed overflow flag |
| flags_q | output | 4 | Registered flags {neg, zero, carry, ovf} |

## Verification
A directed set of operand pairs is applied first:
- zero with zero;
- the largest positive value plus one;
- the most negative value minus one;
- negation of zero and of the most negative value;
- all-ones plus one;
- mixed-sign sums with and without a carry.

These pairs separate a true signed overflow from a plain carry out, and a borrow from no borrow. They also show that the carry input is ignored outside add-with-carry. A long run of pseudo-random operands and operations then covers every sign combination of each operation. In that run the flag register enable is toggled, so a load can be told apart from a hold.

// File: rtl/arith_flag_unit.sv
module arith_flag_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   op_sel,
  input  logic         carry_in,
  input  logic         flag_we,
  output logic [W-1:0] result,
  output logic         neg,
  output logic         zero,
  output logic         carry,
  output logic         ovf,
  output logic [3:0]   flags_q
);

  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_ADC = 2'b01;
  localparam logic [1:0] OP_SUB = 2'b10;
  localparam logic [1:0] OP_NEG = 2'b11;

  logic [W-1:0] a_eff;
  logic [W-1:0] b_eff;
  logic         lsb_cin;
  logic [W:0]   cy;

  always_comb begin
    a_eff   = op_a;
    b_eff   = op_b;
    lsb_cin = 1'b0;
    case (op_sel)
      OP_ADD: lsb_cin = 1'b0;
      OP_ADC: lsb_cin = carry_in;
      OP_SUB: begin
        b_eff   = ~op_b;
        lsb_cin = 1'b1;
      end
      OP_NEG: begin
        a_eff   = '0;
        b_eff   = ~op_a;
        lsb_cin = 1'b1;
      end
      default: lsb_cin = 1'b0;
    endcase
  end

  assign cy[0] = lsb_cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign result[i] = a_eff[i] ^ b_eff[i] ^ cy[i];
    assign cy[i+1]   = (a_eff[i] & b_eff[i]) | (cy[i] & (a_eff[i] ^ b_eff[i]));
  end

  assign carry = cy[W];
  assign ovf   = cy[W] ^ cy[W-1];
  assign neg   = result[W-1];
  assign zero  = ~|result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (flag_we) flags_q <= {neg, zero, carry, ovf};
  end

endmodule

// File: rtl/arith_flag_unit_chk.sv
module arith_flag_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [1:0]   op_sel,
  input logic         carry_in,
  input logic         flag_we,
  input logic [W-1:0] result,
  input logic         neg,
  input logic         zero,
  input logic         carry,
  input logic         ovf,
  input logic [3:0]   flags_q
);

  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  a_r1_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b00) |-> ({carry, result} == ({1'b0, op_a} + {1'b0, op_b})));

  a_r2_adc_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b01) |-> ({carry, result} == ({1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in})));

  a_r3_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b10) |-> (result == op_a - op_b) && (carry == (op_a >= op_b)));

  a_r4_neg_value: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b11) |-> (result == W'(0) - op_a) && (carry == (op_a == '0)));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_sel[1] && (op_a[W-1] != op_b[W-1])) |-> !ovf);

  a_r7_sub_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b10) |-> (ovf == ((op_a[W-1] != op_b[W-1]) && (result[W-1] != op_a[W-1]))));

  a_r8_min_negate: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b11 && op_a == MIN_NEG) |-> ovf && (result == MIN_NEG));

  a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    zero |-> (result == '0) && !neg);

  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flags_q == $past({neg, zero, carry, ovf})));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags_q));

endmodule

bind arith_flag_unit arith_flag_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
  .carry_in(carry_in), .flag_we(flag_we), .result(result), .neg(neg),
  .zero(zero), .carry(carry), .ovf(ovf), .flags_q(flags_q)
);

// File: tb/arith_flag_unit_bench.sv
module arith_flag_unit_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [1:0]   op_sel = 2'b00;
  logic         carry_in = 1'b0;
  logic         flag_we = 1'b0;
  logic [W-1:0] result;
  logic         neg, zero, carry, ovf;
  logic [3:0]   flags_q;

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_flags = '0;

  always #2 clk = ~clk;

  arith_flag_unit #(.W(W)) u_arith_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .carry_in(carry_in), .flag_we(flag_we), .result(result), .neg(neg),
    .zero(zero), .carry(carry), .ovf(ovf), .flags_q(flags_q)
  );

  task automatic model(input logic [7:0] a, input logic [7:0] b, input logic [1:0] op,
                       input logic ci, output logic [7:0] r, output logic [3:0] f);
    int ua = int'(a);
    int ub = int'(b);
    int sa = int'($signed(a));
    int sb = int'($signed(b));
    int t  = 0;
    int st = 0;
    logic c = 1'b0;
    case (op)
      2'b00: begin t = ua + ub;      st = sa + sb;      c = (t > 255); end
      2'b01: begin t = ua + ub + ci; st = sa + sb + ci; c = (t > 255); end
      2'b10: begin t = ua - ub;      st = sa - sb;      c = (ua >= ub); end
      default: begin t = -ua;        st = -sa;          c = (ua == 0); end
    endcase
    r = 8'(t & 255);
    f = {r[7], (r == 8'd0), c, ((st > 127) || (st < -128))};
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h op=%b ci=%b)",
               req, act, expv, op_a, op_b, op_sel, carry_in);
    end
  endtask

  function automatic string req_of(input logic [1:0] op);
    case (op)
      2'b00: return "R1/R5/R6/R9";
      2'b01: return "R2/R5/R6/R9";
      2'b10: return "R3/R5/R7/R9";
      default: return "R4/R5/R8/R9";
    endcase
  endfunction

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [1:0] op,
                       input logic ci, input logic we);
    logic [7:0] er;
    logic [3:0] ef;
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; carry_in = ci; flag_we = we;
    model(a, b, op, ci, er, ef);
    #1;
    check(req_of(op), {result, neg, zero, carry, ovf, 4'h0}, {er, ef, 4'h0});
    if (we) exp_flags = ef;
    @(posedge clk);
    #1;
    check("R10 flag register", {12'h0, flags_q}, {12'h0, exp_flags});
  endtask

  initial begin : watchdog
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset", {12'h0, flags_q}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    apply(8'h00, 8'h00, 2'b00, 1'b1, 1'b1);
    apply(8'h7F, 8'h01, 2'b00, 1'b0, 1'b1);
    apply(8'hFF, 8'h01, 2'b00, 1'b1, 1'b0);
    apply(8'h03, 8'h02, 2'b00, 1'b0, 1'b1);
    apply(8'h04, 8'hFD, 2'b00, 1'b0, 1'b1);
    apply(8'h7F, 8'h80, 2'b01, 1'b1, 1'b1);
    apply(8'h7F, 8'h00, 2'b01, 1'b1, 1'b1);
    apply(8'hFF, 8'hFF, 2'b01, 1'b1, 1'b0);
    apply(8'h80, 8'h01, 2'b10, 1'b0, 1'b1);
    apply(8'h05, 8'h05, 2'b10, 1'b0, 1'b1);
    apply(8'h01, 8'h02, 2'b10, 1'b1, 1'b1);
    apply(8'h7F, 8'hFF, 2'b10, 1'b0, 1'b1);
    apply(8'h80, 8'h55, 2'b11, 1'b1, 1'b1);
    apply(8'h00, 8'hAA, 2'b11, 1'b0, 1'b1);
    apply(8'h01, 8'h00, 2'b11, 1'b0, 1'b0);
    apply(8'h81, 8'h00, 2'b11, 1'b1, 1'b1);

    for (int k = 0; k < 4000; k++) begin
      apply(8'($urandom), 8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule